// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces the five timing strobes that frame an interlaced standard-definition picture in master mode: line-active (hvalid), line sync (hsync), field-active (vvalid), field-boundary sync (vsync) and field identity (fsync). A pixel counter and a line counter step through a frame whose size follows the standard select. Every strobe edge is placed by a run-time setting. Pixel data, clock inversion and locking to an external sync are handled elsewhere.

The vertical sync and field identity edges do not sit on a line boundary. They sit a programmable number of cycles past the end of line-active on their boundary line, and each field has its own vsync offset. Polarity and the first-field level of the field identity come from one packed 5-bit word.

All settings are sampled together on the first cycle of each frame. A change made mid-frame therefore never cuts a pulse short or repeats one. Each output is registered. The value seen in a cycle describes the counter position of the previous cycle, so the first cycle after reset shows pixel 0 of line 1.

Top module: `ilace_sync_gen`

## Requirements
- R1: While rst_n is low, all five outputs are 0. The counters restart at pixel 0 of line 1.
- R2: Raw hsync is active on pixels p with hs_begin <= p < hs_finish on every line. The hsync output equals raw XOR polarity bit 1.
- R3: Raw hvalid is active on pixels p with hs_finish <= p < hs_begin + hact_len. The end position E = hs_begin + hact_len is the reference for the vertical edges. The hvalid output equals raw XNOR polarity bit 0.
- R4: Raw vsync rises at pixel E + vs_f1_ofs of line vs_f1_first and falls at that pixel of line vs_f1_last. It also rises at pixel E + vs_f2_ofs of line vs_f2_first and falls at that pixel of line vs_f2_last. A fall wins over a rise in the same cycle. The vsync output equals raw XOR polarity bit 3.
- R5: The field flag is set at pixel E + fid_ofs of line fid_f1_line and cleared at that pixel of line fid_f2_line. It is 0 after reset. The fsync output is polarity bit 4 while the flag is set and its complement otherwise.
- R6: Raw vvalid is active on lines L with vact_f1_top <= L < vact_f1_top + vact_lines, or with vact_f2_top <= L < vact_f2_top + vact_lines. The vvalid output equals raw XNOR polarity bit 2.
- R7: Polarity bits 0 and 2 at 1 give active-high hvalid and vvalid. Bits 1 and 3 at 1 give active-low hsync and vsync. Bit 4 is the fsync level during the first field.
- R8: With std_sel 0 a line lasts NTSC_LINE_CYC cycles and a frame NTSC_FRAME_LINES lines. With std_sel 1 the values are PAL_LINE_CYC and PAL_FRAME_LINES. Lines are numbered from 1 and pixels from 0.
- R9: All settings, std_sel included, are sampled only in the cycle at pixel 0 of line 1. A change at any other time has no effect on the outputs until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | 0: 525-line standard, 1: 625-line standard |
| hs_begin | input | 11 | First pixel of hsync |
| hs_finish | input | 11 | Pixel after the last hsync pixel; first hvalid pixel |
| hact_len | input | 11 | Cycles from hs_begin to the end of hvalid |
| vs_f1_first | input | 10 | Line on which vsync rises in field 1 |
| vs_f1_last | input | 10 | Line on which vsync falls in field 1 |
| vs_f1_ofs | input | 11 | Cycles after E for field-1 vsync edges |
| vs_f2_first | input | 10 | Line on which vsync rises in field 2 |
| vs_f2_last | input | 10 | Line on which vsync falls in field 2 |
| vs_f2_ofs | input | 11 | Cycles after E for field-2 vsync edges |
| fid_f1_line | input | 10 | Line on which the field flag is set |
| fid_f2_line | input | 10 | Line on which the field flag is cleared |
| fid_ofs | input | 11 | Cycles after E for the field flag edges |
| vact_f1_top | input | 10 | First active line of field 1 |
| vact_f2_top | input | 10 | First active line of field 2 |
| vact_lines | input | 10 | Active lines per field |
| polarity | input | 5 | Packed polarity and first-field level (R7) |
| hvalid_o | output | 1 | Line-active strobe |
| hsync_o | output | 1 | Line sync |
| vvalid_o | output | 1 | Field-active strobe |
| vsync_o | output | 1 | Field-boundary sync |
| fsync_o | output | 1 | Field identity |

## Verification
The assertions assume a sane setting set:
- hs_begin is below hs_finish.
- Every edge position E plus its offset is smaller than the line length, so each programmed edge actually occurs.
- The vsync rise and fall lines of a field differ.
- The two field flag lines differ.

The stimulus uses only such sets. It shrinks each standard's line and frame size through the parameters, so that whole frames can be swept cycle by cycle. It changes settings only between clock edges and deliberately in mid-frame, to show that they are deferred until the next frame start.

// File: rtl/ilsg_pkg.sv
package ilsg_pkg;
  parameter int PIX_W  = 11;
  parameter int LINE_W = 10;
  localparam int POS_W = PIX_W + 2;
  localparam int NFLD  = 2;

  localparam int POL_HV  = 0;
  localparam int POL_HS  = 1;
  localparam int POL_VV  = 2;
  localparam int POL_VS  = 3;
  localparam int POL_FID = 4;

  typedef struct packed {
    logic                               std;
    logic [PIX_W-1:0]                   hs_begin;
    logic [PIX_W-1:0]                   hs_finish;
    logic [PIX_W-1:0]                   hact_len;
    logic [NFLD-1:0][LINE_W-1:0]        vs_first;
    logic [NFLD-1:0][LINE_W-1:0]        vs_last;
    logic [NFLD-1:0][PIX_W-1:0]         vs_ofs;
    logic [NFLD-1:0][LINE_W-1:0]        fid_line;
    logic [PIX_W-1:0]                   fid_ofs;
    logic [NFLD-1:0][LINE_W-1:0]        vact_top;
    logic [LINE_W-1:0]                  vact_lines;
    logic [4:0]                         pol;
  } ilsg_cfg_t;
endpackage

// File: rtl/ilsg_line_ctr.sv
module ilsg_line_ctr
  import ilsg_pkg::*;
#(
  parameter int LEN0   = 858,
  parameter int LINES0 = 525,
  parameter int LEN1   = 864,
  parameter int LINES1 = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output logic              frame_start
);
  localparam logic [PIX_W-1:0]  LAST_PIX0  = PIX_W'(LEN0 - 1);
  localparam logic [PIX_W-1:0]  LAST_PIX1  = PIX_W'(LEN1 - 1);
  localparam logic [LINE_W-1:0] LAST_LINE0 = LINE_W'(LINES0);
  localparam logic [LINE_W-1:0] LAST_LINE1 = LINE_W'(LINES1);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

  logic [PIX_W-1:0]  last_pix;
  logic [LINE_W-1:0] last_line;

  assign last_pix    = std_sel ? LAST_PIX1 : LAST_PIX0;
  assign last_line   = std_sel ? LAST_LINE1 : LAST_LINE0;
  assign frame_start = (pix == '0) && (line == FIRST_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= FIRST_LINE;
    end else if (pix >= last_pix) begin
      pix  <= '0;
      line <= (line >= last_line) ? FIRST_LINE : line + 1'b1;
    end else begin
      pix <= pix + 1'b1;
    end
  end

  // line length bound for the standard in force
  assert_pix_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix <= last_pix);
  // frame height bound, numbering from 1
  assert_line_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line >= FIRST_LINE) && (line <= last_line));
  // the line number moves only when the pixel count wraps
  assert_line_steps_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix != '0) |-> $stable(line));
endmodule

// File: rtl/ilsg_cfg_shadow.sv
module ilsg_cfg_shadow
  import ilsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start,
  input  ilsg_cfg_t cfg_in,
  output ilsg_cfg_t cfg_eff
);
  ilsg_cfg_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held <= '0;
    else if (frame_start) held <= cfg_in;
  end

  // the frame-start cycle already uses the freshly presented values
  assign cfg_eff = frame_start ? cfg_in : held;

  // the held copy changes only right after a frame start
  assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(held));
  // settings in force never move inside a frame
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(cfg_eff));
endmodule

// File: rtl/ilsg_vert_events.sv
module ilsg_vert_events
  import ilsg_pkg::*;
(
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  ilsg_cfg_t         cfg,
  output logic [POS_W-1:0]  hv_end,
  output logic              vs_on,
  output logic              vs_off,
  output logic              fid_set,
  output logic              fid_clr,
  output logic              vact_raw
);
  logic [POS_W-1:0] at_pos;
  logic [POS_W-1:0] fid_pos;
  logic [NFLD-1:0]  on_f, off_f, act_f;

  assign at_pos  = POS_W'(pix);
  assign hv_end  = POS_W'(cfg.hs_begin) + POS_W'(cfg.hact_len);
  assign fid_pos = hv_end + POS_W'(cfg.fid_ofs);

  for (genvar f = 0; f < NFLD; f++) begin : g_field
    logic [POS_W-1:0]  edge_pos;
    logic [LINE_W:0]   top_ext;
    logic [LINE_W:0]   bot_ext;
    assign edge_pos = hv_end + POS_W'(cfg.vs_ofs[f]);
    assign on_f[f]  = (line == cfg.vs_first[f]) && (at_pos == edge_pos);
    assign off_f[f] = (line == cfg.vs_last[f])  && (at_pos == edge_pos);
    assign top_ext  = {1'b0, cfg.vact_top[f]};
    assign bot_ext  = top_ext + {1'b0, cfg.vact_lines};
    assign act_f[f] = ({1'b0, line} >= top_ext) && ({1'b0, line} < bot_ext);
  end

  assign vs_on    = |on_f;
  assign vs_off   = |off_f;
  assign fid_set  = (line == cfg.fid_line[0]) && (at_pos == fid_pos);
  assign fid_clr  = (line == cfg.fid_line[1]) && (at_pos == fid_pos);
  assign vact_raw = |act_f;
endmodule

// File: rtl/ilace_sync_gen.sv
module ilace_sync_gen
  import ilsg_pkg::*;
#(
  parameter int NTSC_LINE_CYC    = 858,
  parameter int NTSC_FRAME_LINES = 525,
  parameter int PAL_LINE_CYC     = 864,
  parameter int PAL_FRAME_LINES  = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel,
  input  logic [PIX_W-1:0]  hs_begin,
  input  logic [PIX_W-1:0]  hs_finish,
  input  logic [PIX_W-1:0]  hact_len,
  input  logic [LINE_W-1:0] vs_f1_first,
  input  logic [LINE_W-1:0] vs_f1_last,
  input  logic [PIX_W-1:0]  vs_f1_ofs,
  input  logic [LINE_W-1:0] vs_f2_first,
  input  logic [LINE_W-1:0] vs_f2_last,
  input  logic [PIX_W-1:0]  vs_f2_ofs,
  input  logic [LINE_W-1:0] fid_f1_line,
  input  logic [LINE_W-1:0] fid_f2_line,
  input  logic [PIX_W-1:0]  fid_ofs,
  input  logic [LINE_W-1:0] vact_f1_top,
  input  logic [LINE_W-1:0] vact_f2_top,
  input  logic [LINE_W-1:0] vact_lines,
  input  logic [4:0]        polarity,
  output logic              hvalid_o,
  output logic              hsync_o,
  output logic              vvalid_o,
  output logic              vsync_o,
  output logic              fsync_o
);
  ilsg_cfg_t         cfg_in, cfg_eff;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              frame_start;
  logic [POS_W-1:0]  hv_end;
  logic              vs_on, vs_off, fid_set, fid_clr, vact_raw;
  logic              hs_raw, hv_raw, vs_next, fid_next;
  logic              vs_q, fid_q, vv_raw_q;

  always_comb begin
    cfg_in             = '0;
    cfg_in.std         = std_sel;
    cfg_in.hs_begin    = hs_begin;
    cfg_in.hs_finish   = hs_finish;
    cfg_in.hact_len    = hact_len;
    cfg_in.vs_first[0] = vs_f1_first;
    cfg_in.vs_last[0]  = vs_f1_last;
    cfg_in.vs_ofs[0]   = vs_f1_ofs;
    cfg_in.vs_first[1] = vs_f2_first;
    cfg_in.vs_last[1]  = vs_f2_last;
    cfg_in.vs_ofs[1]   = vs_f2_ofs;
    cfg_in.fid_line[0] = fid_f1_line;
    cfg_in.fid_line[1] = fid_f2_line;
    cfg_in.fid_ofs     = fid_ofs;
    cfg_in.vact_top[0] = vact_f1_top;
    cfg_in.vact_top[1] = vact_f2_top;
    cfg_in.vact_lines  = vact_lines;
    cfg_in.pol         = polarity;
  end

  ilsg_line_ctr #(
    .LEN0(NTSC_LINE_CYC), .LINES0(NTSC_FRAME_LINES),
    .LEN1(PAL_LINE_CYC),  .LINES1(PAL_FRAME_LINES)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .std_sel(cfg_eff.std),
    .pix(pix), .line(line), .frame_start(frame_start)
  );

  ilsg_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_in(cfg_in), .cfg_eff(cfg_eff)
  );

  ilsg_vert_events u_vev (
    .pix(pix), .line(line), .cfg(cfg_eff), .hv_end(hv_end),
    .vs_on(vs_on), .vs_off(vs_off), .fid_set(fid_set), .fid_clr(fid_clr),
    .vact_raw(vact_raw)
  );

  assign hs_raw   = (pix >= cfg_eff.hs_begin) && (pix < cfg_eff.hs_finish);
  assign hv_raw   = (POS_W'(pix) >= POS_W'(cfg_eff.hs_finish)) && (POS_W'(pix) < hv_end);
  assign vs_next  = vs_off ? 1'b0 : (vs_on ? 1'b1 : vs_q);
  assign fid_next = fid_set ? 1'b1 : (fid_clr ? 1'b0 : fid_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q     <= 1'b0;
      fid_q    <= 1'b0;
      vv_raw_q <= 1'b0;
      hvalid_o <= 1'b0;
      hsync_o  <= 1'b0;
      vvalid_o <= 1'b0;
      vsync_o  <= 1'b0;
      fsync_o  <= 1'b0;
    end else begin
      vs_q     <= vs_next;
      fid_q    <= fid_next;
      vv_raw_q <= vact_raw;
      hvalid_o <= hv_raw   ^ ~cfg_eff.pol[POL_HV];
      hsync_o  <= hs_raw   ^  cfg_eff.pol[POL_HS];
      vvalid_o <= vact_raw ^ ~cfg_eff.pol[POL_VV];
      vsync_o  <= vs_next  ^  cfg_eff.pol[POL_VS];
      fsync_o  <= fid_next ? cfg_eff.pol[POL_FID] : ~cfg_eff.pol[POL_FID];
    end
  end

  // vsync state moves only on a programmed edge event
  assert_vsync_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_q != $past(vs_q)) |-> $past(vs_on || vs_off));
  // field flag moves only on a programmed edge event
  assert_fid_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_q != $past(fid_q)) |-> $past(fid_set || fid_clr));
  // field-active decode can change only one cycle after a line boundary
  assert_vact_line_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix != PIX_W'(1)) |-> $stable(vv_raw_q));
  // a set and a clear of the field flag never coincide
  assert_fid_events_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fid_set && fid_clr));
endmodule

// File: tb/ilace_sync_gen_tb_top.sv
module ilace_sync_gen_tb_top;
  localparam int LL0 = 40, NL0 = 21, LL1 = 48, NL1 = 25;
  localparam int PW = 11, LW = 10;
  localparam int STD = 0, HSB = 1, HSF = 2, HAL = 3, V1F = 4, V1L = 5, V1O = 6,
                 V2F = 7, V2L = 8, V2O = 9, F1L = 10, F2L = 11, FO = 12,
                 T1 = 13, T2 = 14, VAL = 15, POL = 16, NC = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int c [NC];
  int s [NC];
  int m_pix, m_line, m_vs, m_fl;
  int vectors = 0, fails = 0;
  bit done = 0;

  logic hvalid_o, hsync_o, vvalid_o, vsync_o, fsync_o;

  ilace_sync_gen #(
    .NTSC_LINE_CYC(LL0), .NTSC_FRAME_LINES(NL0),
    .PAL_LINE_CYC(LL1),  .PAL_FRAME_LINES(NL1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .std_sel(c[STD][0]),
    .hs_begin(PW'(c[HSB])), .hs_finish(PW'(c[HSF])), .hact_len(PW'(c[HAL])),
    .vs_f1_first(LW'(c[V1F])), .vs_f1_last(LW'(c[V1L])), .vs_f1_ofs(PW'(c[V1O])),
    .vs_f2_first(LW'(c[V2F])), .vs_f2_last(LW'(c[V2L])), .vs_f2_ofs(PW'(c[V2O])),
    .fid_f1_line(LW'(c[F1L])), .fid_f2_line(LW'(c[F2L])), .fid_ofs(PW'(c[FO])),
    .vact_f1_top(LW'(c[T1])), .vact_f2_top(LW'(c[T2])), .vact_lines(LW'(c[VAL])),
    .polarity(5'(c[POL])),
    .hvalid_o(hvalid_o), .hsync_o(hsync_o), .vvalid_o(vvalid_o),
    .vsync_o(vsync_o), .fsync_o(fsync_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at line %0d pix %0d: got %b expected %b", tag, m_line, m_pix, act, exp);
    end
  endtask

  // small 525-style setting, default polarity
  task automatic cfg_a(input int pol);
    c[STD] = 0; c[HSB] = 2; c[HSF] = 6; c[HAL] = 30;
    c[V1F] = 2; c[V1L] = 4; c[V1O] = 3; c[V2F] = 12; c[V2L] = 14; c[V2O] = 6;
    c[F1L] = 2; c[F2L] = 12; c[FO] = 1;
    c[T1] = 4; c[T2] = 14; c[VAL] = 6; c[POL] = pol;
  endtask

  // small 625-style setting, all polarities flipped
  task automatic cfg_b();
    c[STD] = 1; c[HSB] = 3; c[HSF] = 9; c[HAL] = 35;
    c[V1F] = 1; c[V1L] = 3; c[V1O] = 2; c[V2F] = 13; c[V2L] = 15; c[V2O] = 9;
    c[F1L] = 1; c[F2L] = 13; c[FO] = 0;
    c[T1] = 3; c[T2] = 15; c[VAL] = 8; c[POL] = 5'b11010;
  endtask

  // expected outputs for the current model position, then advance it (R2..R9)
  task automatic model_step();
    int e, ll, nl;
    logic hs, hv, vv, vset, vclr;
    if (m_pix == 0 && m_line == 1) s = c;   // R9: sampled only at frame start
    e  = s[HSB] + s[HAL];
    hs = (m_pix >= s[HSB]) && (m_pix < s[HSF]);
    hv = (m_pix >= s[HSF]) && (m_pix < e);
    vv = ((m_line >= s[T1]) && (m_line < s[T1] + s[VAL])) ||
         ((m_line >= s[T2]) && (m_line < s[T2] + s[VAL]));
    vset = ((m_line == s[V1F]) && (m_pix == e + s[V1O])) ||
           ((m_line == s[V2F]) && (m_pix == e + s[V2O]));
    vclr = ((m_line == s[V1L]) && (m_pix == e + s[V1O])) ||
           ((m_line == s[V2L]) && (m_pix == e + s[V2O]));
    if (vclr) m_vs = 0; else if (vset) m_vs = 1;
    if ((m_line == s[F1L]) && (m_pix == e + s[FO])) m_fl = 1;
    else if ((m_line == s[F2L]) && (m_pix == e + s[FO])) m_fl = 0;
    chk("R2 R7 R9 hsync",  hsync_o,  hs ^ s[POL][1]);
    chk("R3 R7 R9 hvalid", hvalid_o, hv ^ ~s[POL][0]);
    chk("R6 R7 vvalid",    vvalid_o, vv ^ ~s[POL][2]);
    chk("R4 R7 vsync",     vsync_o,  logic'(m_vs) ^ s[POL][3]);
    chk("R5 R7 fsync",     fsync_o,  (m_fl != 0) ? s[POL][4] : ~s[POL][4]);
    ll = s[STD][0] ? LL1 : LL0;             // R8: frame geometry per standard
    nl = s[STD][0] ? NL1 : NL0;
    if (m_pix == ll - 1) begin
      m_pix  = 0;
      m_line = (m_line == nl) ? 1 : m_line + 1;
    end else begin
      m_pix++;
    end
  endtask

  initial begin
    cfg_a(5'b00101);
    for (int i = 0; i < NC; i++) s[i] = 0;
    repeat (3) begin
      @(negedge clk);
      // R1: outputs held low in reset
      chk("R1 hvalid", hvalid_o, 1'b0);
      chk("R1 hsync",  hsync_o,  1'b0);
      chk("R1 vvalid", vvalid_o, 1'b0);
      chk("R1 vsync",  vsync_o,  1'b0);
      chk("R1 fsync",  fsync_o,  1'b0);
    end
    rst_n = 1'b1;
    m_pix = 0; m_line = 1; m_vs = 0; m_fl = 0;
    for (int cyc = 0; cyc < 7000; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      model_step();
      if (cyc == 1700) cfg_b();             // mid-frame change, R9
      if (cyc == 5000) cfg_a(5'b10110);     // back to 525 lines, mixed polarity
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule